// File: doc/BRIEF.md
# TDM to four-lane I2S bridge

This block takes a single serial TDM audio stream carrying eight channels and re-emits the same audio as four stereo I2S data lines. All four lines share one I2S bit clock and one word select. The only clock is the incoming TDM bit clock, and the block needs no PLL. The I2S bit clock is that clock divided by an integer ratio, three by default. At the default sizes, a TDM frame of eight 24-bit slots lasts exactly as long as an I2S frame of two 32-bit slots at one third of the rate.

Incoming bits fill one bank of a two-bank frame store. The other bank, holding the frame that arrived before, is read out as I2S. A frame-sync pulse swaps the banks and restarts the I2S timing, so every I2S frame starts in step with a TDM frame. Audio is therefore delayed by exactly one frame. Both sides are continuous, clock-driven streams. There is no valid/ready handshake and no back-pressure: the source never stalls and the sink must take every bit clock. A frame that arrives short is replaced by silence rather than held off.

Top module: `tdm2i2s_bridge`

## Requirements
- R1: A TDM frame starts in the cycle whose rising `tdm_bclk` edge samples `tdm_fsync` high. The data bit in that cycle is the MSB of channel 0. Channels 0..7 follow, each in a 24-bit slot, MSB first, for 192 bits per frame.
- R2: TDM channel 2k is sent in the left slot of `i2s_sd[k]`, and channel 2k+1 in the right slot, for k = 0..3.
- R3: Each I2S slot is 32 bits, MSB first. The 24-bit sample occupies slot bits 31..8, and slot bits 7..0 are always 0.
- R4: `i2s_bclk` is low for one `tdm_bclk` cycle and then high for two, repeating. `i2s_ws` and `i2s_sd` change only when `i2s_bclk` is entering its low phase, which is its falling edge.
- R5: `i2s_ws` is 0 for the left slot and 1 for the right slot, and toggles every 32 I2S bit periods. The MSB of a slot appears one I2S bit period after the `i2s_ws` transition that announces that slot.
- R6: The I2S frame that begins at a frame sync carries the complete TDM frame that ended at that frame sync, which is exactly one frame of latency.
- R7: `i2s_sd` is all zeros until a first complete TDM frame has been captured. It is also all zeros for the whole I2S frame that follows a TDM frame of fewer than 192 bits.
- R8: Bits received after the 192nd bit of a frame and before the next frame sync are ignored. Without a frame sync, the I2S timing wraps every 192 cycles and replays the same stored frame.
- R9: In the cycle after `tdm_fsync` is sampled high, the I2S side is at bit period 0: `i2s_bclk` is low and `i2s_ws` is low, whatever phase it was in before.
- R10: While `rst_n` is low, `i2s_bclk`, `i2s_ws` and `i2s_sd` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tdm_bclk | input | 1 | TDM bit clock; the block's only clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| tdm_fsync | input | 1 | Frame-sync pulse, high during the first bit of a frame |
| tdm_sdata | input | 1 | Serial TDM data |
| i2s_bclk | output | 1 | I2S bit clock, `tdm_bclk` divided by three |
| i2s_ws | output | 1 | I2S word select, 0 for left and 1 for right |
| i2s_sd | output | 4 | I2S data lines, one stereo pair per bit |

## Verification
The bench builds the bridge with its default parameters: eight channels, 24-bit TDM slots, 32-bit I2S slots and a divide ratio of three. At these values a whole frame is only 192 cycles, so every cycle of a dozen frames can be predicted arithmetically and compared. That covers every slot bit, all four lanes, both padding regions and each word-select edge. Within the same short run it feeds all-ones and all-zeros frames, a truncated frame that forces a silent frame afterwards, and an over-long frame whose extra bits must vanish while the I2S timing wraps.

// File: rtl/tdm2i2s_pkg.sv
package tdm2i2s_pkg;
  // Default sizing shared by the bridge and its sub-blocks.
  localparam int DEF_NUM_CH     = 8;
  localparam int DEF_TDM_SLOT_W = 24;
  localparam int DEF_I2S_SLOT_W = 32;
  localparam int DEF_BCLK_DIV   = 3;

  // Stereo side carried by an I2S slot.
  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } side_e;
endpackage

// File: rtl/tdm_frame_capture.sv
// Deserialises one TDM frame into a two-bank store; the bank not being
// written is presented whole to the I2S side.
module tdm_frame_capture #(
  parameter int NUM_CH = tdm2i2s_pkg::DEF_NUM_CH,
  parameter int SLOT_W = tdm2i2s_pkg::DEF_TDM_SLOT_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           fsync,
  input  logic                           sdata,
  output logic [NUM_CH-1:0][SLOT_W-1:0]  rd_frame,
  output logic                           rd_valid
);
  localparam int SLOT_CW = $clog2(NUM_CH + 1);
  localparam int CH_IW   = $clog2(NUM_CH);
  localparam int BIT_W   = $clog2(SLOT_W);

  logic [NUM_CH-1:0][SLOT_W-1:0] bank_q [2];
  logic                          wsel_q;
  logic                          started_q;
  logic                          valid_q;
  logic [SLOT_CW-1:0]            slot_q;
  logic [BIT_W-1:0]              sbit_q;
  logic                          frame_full;
  logic [BIT_W-1:0]              wr_pos;

  // All slots written: the frame is complete and further bits are dropped.
  assign frame_full = (slot_q == SLOT_CW'(NUM_CH));
  // Bits arrive MSB first inside each slot.
  assign wr_pos     = BIT_W'(SLOT_W - 1) - sbit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q[0] <= '0;
      bank_q[1] <= '0;
      wsel_q    <= 1'b0;
      started_q <= 1'b0;
      valid_q   <= 1'b0;
      slot_q    <= SLOT_CW'(NUM_CH);
      sbit_q    <= '0;
    end else if (fsync) begin
      // Swap banks; the first bit of the new frame lands in the fresh bank.
      bank_q[~wsel_q][0][SLOT_W-1] <= sdata;
      wsel_q    <= ~wsel_q;
      started_q <= 1'b1;
      valid_q   <= started_q && frame_full;
      slot_q    <= '0;
      sbit_q    <= BIT_W'(1);
    end else if (!frame_full) begin
      bank_q[wsel_q][slot_q[CH_IW-1:0]][wr_pos] <= sdata;
      if (sbit_q == BIT_W'(SLOT_W - 1)) begin
        sbit_q <= '0;
        slot_q <= slot_q + SLOT_CW'(1);
      end else begin
        sbit_q <= sbit_q + BIT_W'(1);
      end
    end
  end

  assign rd_frame = bank_q[~wsel_q];
  assign rd_valid = valid_q;
endmodule

// File: rtl/i2s_bit_timer.sv
// Divider phase and I2S bit-period position, realigned by frame sync.
// Exposes next-state values so the output stage can register them.
module i2s_bit_timer #(
  parameter int DIV    = tdm2i2s_pkg::DEF_BCLK_DIV,
  parameter int SLOT_W = tdm2i2s_pkg::DEF_I2S_SLOT_W
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               fsync,
  output logic [$clog2(DIV)-1:0]             div_nxt,
  output logic [$clog2(2*SLOT_W)-1:0]        pos_nxt
);
  localparam int DIV_W = $clog2(DIV);
  localparam int POS_W = $clog2(2 * SLOT_W);

  logic [DIV_W-1:0] div_q;
  logic [POS_W-1:0] pos_q;
  logic             div_wrap;
  logic             pos_wrap;

  assign div_wrap = (div_q == DIV_W'(DIV - 1));
  assign pos_wrap = (pos_q == POS_W'(2 * SLOT_W - 1));

  always_comb begin
    if (fsync) begin
      div_nxt = '0;
      pos_nxt = '0;
    end else if (div_wrap) begin
      div_nxt = '0;
      pos_nxt = pos_wrap ? '0 : pos_q + POS_W'(1);
    end else begin
      div_nxt = div_q + DIV_W'(1);
      pos_nxt = pos_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      pos_q <= '0;
    end else begin
      div_q <= div_nxt;
      pos_q <= pos_nxt;
    end
  end
endmodule

// File: rtl/i2s_lane_shifter.sv
// Registered I2S outputs: bit clock, word select and one data line per
// stereo pair, decoded from the timer's next position.
module i2s_lane_shifter #(
  parameter int NUM_CH = tdm2i2s_pkg::DEF_NUM_CH,
  parameter int TDM_W  = tdm2i2s_pkg::DEF_TDM_SLOT_W,
  parameter int I2S_W  = tdm2i2s_pkg::DEF_I2S_SLOT_W,
  parameter int DIV    = tdm2i2s_pkg::DEF_BCLK_DIV
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(DIV)-1:0]        div_nxt,
  input  logic [$clog2(2*I2S_W)-1:0]    pos_nxt,
  input  logic [NUM_CH-1:0][TDM_W-1:0]  rd_frame,
  input  logic                          rd_valid,
  output logic                          bclk,
  output logic                          ws,
  output logic [NUM_CH/2-1:0]           sd
);
  import tdm2i2s_pkg::*;

  localparam int LANES = NUM_CH / 2;
  localparam int POS_W = $clog2(2 * I2S_W);
  localparam int PAD   = I2S_W - TDM_W;
  localparam int IDX_W = $clog2(TDM_W);

  side_e            side;
  logic [POS_W-1:0] slot_bit;
  logic             carries_sample;
  logic [IDX_W-1:0] smp_idx;
  logic [LANES-1:0] sd_d;

  // One-period delay: position 1..I2S_W is left, the rest is right,
  // and position 0 is the tail (LSB) of the previous right slot.
  always_comb begin
    if (pos_nxt > POS_W'(I2S_W)) begin
      side     = SIDE_RIGHT;
      slot_bit = POS_W'(I2S_W) - (pos_nxt - POS_W'(I2S_W));
    end else begin
      side     = SIDE_LEFT;
      slot_bit = POS_W'(I2S_W) - pos_nxt;
    end
    carries_sample = rd_valid && (pos_nxt != '0) && (slot_bit >= POS_W'(PAD));
    smp_idx        = IDX_W'(slot_bit - POS_W'(PAD));
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [TDM_W-1:0] left_smp;
    logic [TDM_W-1:0] right_smp;
    assign left_smp  = rd_frame[2*k];
    assign right_smp = rd_frame[2*k+1];
    assign sd_d[k]   = carries_sample &&
                       ((side == SIDE_RIGHT) ? right_smp[smp_idx] : left_smp[smp_idx]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk <= 1'b0;
      ws   <= 1'b0;
      sd   <= '0;
    end else begin
      bclk <= (div_nxt != '0);
      ws   <= (pos_nxt >= POS_W'(I2S_W));
      sd   <= sd_d;
    end
  end
endmodule

// File: rtl/tdm2i2s_bridge.sv
module tdm2i2s_bridge #(
  parameter int NUM_CH     = tdm2i2s_pkg::DEF_NUM_CH,
  parameter int TDM_SLOT_W = tdm2i2s_pkg::DEF_TDM_SLOT_W,
  parameter int I2S_SLOT_W = tdm2i2s_pkg::DEF_I2S_SLOT_W,
  parameter int BCLK_DIV   = tdm2i2s_pkg::DEF_BCLK_DIV
) (
  input  logic                  tdm_bclk,
  input  logic                  rst_n,
  input  logic                  tdm_fsync,
  input  logic                  tdm_sdata,
  output logic                  i2s_bclk,
  output logic                  i2s_ws,
  output logic [NUM_CH/2-1:0]   i2s_sd
);
  localparam int DIV_W = $clog2(BCLK_DIV);
  localparam int POS_W = $clog2(2 * I2S_SLOT_W);

  // Both frames must span the same number of TDM bit clocks.
  if (NUM_CH * TDM_SLOT_W != 2 * I2S_SLOT_W * BCLK_DIV) begin : g_bad_ratio
    $error("TDM and I2S frame lengths differ");
  end

  logic [NUM_CH-1:0][TDM_SLOT_W-1:0] rd_frame;
  logic                              rd_valid;
  logic [DIV_W-1:0]                  div_nxt;
  logic [POS_W-1:0]                  pos_nxt;

  tdm_frame_capture #(
    .NUM_CH (NUM_CH),
    .SLOT_W (TDM_SLOT_W)
  ) u_capture (
    .clk      (tdm_bclk),
    .rst_n    (rst_n),
    .fsync    (tdm_fsync),
    .sdata    (tdm_sdata),
    .rd_frame (rd_frame),
    .rd_valid (rd_valid)
  );

  i2s_bit_timer #(
    .DIV    (BCLK_DIV),
    .SLOT_W (I2S_SLOT_W)
  ) u_timer (
    .clk     (tdm_bclk),
    .rst_n   (rst_n),
    .fsync   (tdm_fsync),
    .div_nxt (div_nxt),
    .pos_nxt (pos_nxt)
  );

  i2s_lane_shifter #(
    .NUM_CH (NUM_CH),
    .TDM_W  (TDM_SLOT_W),
    .I2S_W  (I2S_SLOT_W),
    .DIV    (BCLK_DIV)
  ) u_shifter (
    .clk      (tdm_bclk),
    .rst_n    (rst_n),
    .div_nxt  (div_nxt),
    .pos_nxt  (pos_nxt),
    .rd_frame (rd_frame),
    .rd_valid (rd_valid),
    .bclk     (i2s_bclk),
    .ws       (i2s_ws),
    .sd       (i2s_sd)
  );
endmodule

// File: rtl/tdm2i2s_bridge_chk.sv
module tdm2i2s_bridge_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fsync,
  input logic             bclk,
  input logic             ws,
  input logic [LANES-1:0] sd
);
  // Frame syncs seen since reset, saturating at two.
  logic [1:0] fs_seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     fs_seen_q <= '0;
    else if (fsync && fs_seen_q != 2'd2) fs_seen_q <= fs_seen_q + 2'd1;
  end

  // R4: the low phase lasts one cycle
  a_r4_low_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (!bclk && !fsync) |=> bclk);
  // R4: the high phase lasts at least two cycles
  a_r4_high_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bclk) && !fsync) |=> bclk);
  // R4: data moves only at the falling edge
  a_r4_sd_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd) |-> !bclk);
  // R5: word select moves only at the falling edge
  a_r5_ws_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws) |-> !bclk);
  // R3: the bit driven with each word-select edge is a padding LSB
  a_r3_pad_at_ws_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ws) |-> (sd == '0));
  a_r3_pad_at_ws_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ws) |-> (sd == '0));
  // R9: frame sync restarts the I2S frame
  a_r9_fsync_realign: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> (!bclk && !ws));
  // R7: silence until a whole frame has been stored
  a_r7_zero_before_first: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_seen_q != 2'd2) |-> (sd == '0));
endmodule

bind tdm2i2s_bridge tdm2i2s_bridge_chk #(
  .LANES (NUM_CH / 2)
) u_chk (
  .clk   (tdm_bclk),
  .rst_n (rst_n),
  .fsync (tdm_fsync),
  .bclk  (i2s_bclk),
  .ws    (i2s_ws),
  .sd    (i2s_sd)
);

// File: tb/tdm2i2s_bridge_tb_top.sv
module tdm2i2s_bridge_tb_top;
  localparam int NCH    = 8;
  localparam int TW     = 24;
  localparam int IW     = 32;
  localparam int DIV    = 3;
  localparam int FBITS  = NCH * TW;
  localparam int LANES  = NCH / 2;
  localparam int NFRM   = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fsync = 1'b0;
  logic sdata = 1'b0;
  logic i2s_bclk;
  logic i2s_ws;
  logic [LANES-1:0] i2s_sd;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  tdm2i2s_bridge #(
    .NUM_CH (NCH), .TDM_SLOT_W (TW), .I2S_SLOT_W (IW), .BCLK_DIV (DIV)
  ) dut_i (
    .tdm_bclk  (clk),
    .rst_n     (rst_n),
    .tdm_fsync (fsync),
    .tdm_sdata (sdata),
    .i2s_bclk  (i2s_bclk),
    .i2s_ws    (i2s_ws),
    .i2s_sd    (i2s_sd)
  );

  // Frame 4 is truncated (R7), frame 7 carries surplus bits (R8).
  function automatic int flen(int f);
    if (f == 4) return 100;
    if (f == 7) return 250;
    return FBITS;
  endfunction

  function automatic logic [TW-1:0] sample(int f, int c);
    if (f == 2) return '1;
    if (f == 3) return '0;
    if (f == 9) return 24'hA5A5A5 ^ TW'(c * 24'h111111);
    return TW'(f * 24'h3A5C7 + c * 24'h81F3B + 24'h124);
  endfunction

  function automatic logic tdm_bit(int f, int j);
    logic [TW-1:0] s;
    if (j >= FBITS) return logic'(((f * 7 + j * 13) % 3) != 0);
    s = sample(f, j / TW);
    return s[TW - 1 - (j % TW)];
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      if (n_fail <= 30)
        $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Outputs shown while bit j of frame of_idx was last driven.
  task automatic check_pos(int of_idx, int j);
    int p = j % FBITS;
    int b = p / DIV;
    bit valid = (of_idx >= 1) && (flen(of_idx - 1) >= FBITS);
    int kk;
    int side;
    logic [LANES-1:0] exp_sd = '0;
    string tag;
    logic [TW-1:0] s;
    if (b == 0) begin kk = 0; side = 1; end
    else if (b <= IW) begin kk = IW - b; side = 0; end
    else begin kk = 2 * IW - b; side = 1; end
    for (int k = 0; k < LANES; k++) begin
      s = sample(of_idx - 1, 2 * k + side);
      if (valid && b != 0 && kk >= IW - TW) exp_sd[k] = s[kk - (IW - TW)];
    end
    if (j >= FBITS)           tag = "R8";
    else if (!valid)          tag = "R7";
    else if (b == 0 || kk < IW - TW) tag = "R3";
    else                      tag = "R1/R2/R6";
    check((p == 0) ? "R9" : "R4", "bclk", int'(i2s_bclk), int'((p % DIV) != 0));
    check((p == 0) ? "R9" : "R5", "ws", int'(i2s_ws), int'(b >= IW));
    check(tag, "sd", int'(i2s_sd), int'(exp_sd));
  endtask

  initial begin
    int pf = 0;
    int pj = 0;
    bit have = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "bclk", int'(i2s_bclk), 0);
    check("R10", "ws", int'(i2s_ws), 0);
    check("R10", "sd", int'(i2s_sd), 0);
    rst_n = 1'b1;
    // R7: idle line before any frame sync
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      sdata = logic'(i % 2);
      check("R7", "sd idle", int'(i2s_sd), 0);
    end
    for (int f = 0; f < NFRM; f++) begin
      for (int j = 0; j < flen(f); j++) begin
        @(negedge clk);
        if (have) check_pos(pf, pj);
        fsync = (j == 0);
        sdata = tdm_bit(f, j);
        pf = f;
        pj = j;
        have = 1'b1;
      end
    end
    @(negedge clk);
    check_pos(pf, pj);
    fsync = 1'b0;
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule